// File: doc/BRIEF.md
# Two-Wire Bus Clock Rate Generator

This block produces the master clock line for a two-wire serial bus, derived from the system clock. A bit-rate value (8 bits) and a prescaler select (2 bits) set the length of each bus clock phase. The block pulls the clock line low through an open-drain enable. It watches the real line level through a synchronizer, so a target that holds the line low extends the low phase. The byte-level master logic receives single-cycle strobes at the start of each low phase and at the start of each counted high phase. Data shifting, start/stop conditions and addressing are handled elsewhere.

With no stretching, each phase lasts `8 + rate * P` system clocks, where P is the prescale factor. The full bus period is therefore `16 + 2 * rate * P` system clocks. The synchronizer delay is counted as part of the high phase, so the formula holds exactly. Bit-rate values below 10 do not work reliably in master operation, and the block raises a warning output while such a value is programmed with the master enabled.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, and while `enable` is low, `scl_pull_low`, `edge_rise` and `edge_fall` are 0.
- R2: `scl_pull_low` stays high for exactly H = 8 + `rate_div` * P system clocks per low phase. P is set by `pre_sel` as 0→1, 1→4, 2→16, 3→64. Stretching does not lengthen how long the block itself pulls low.
- R3: When no device holds the line, the line is released for exactly H cycles between two low phases, so the full period is 16 + 2 * `rate_div` * P cycles.
- R4: `edge_fall` is a one-cycle pulse in the first cycle of every low phase, once per period, and never coincides with `edge_rise`.
- R5: `edge_rise` is a one-cycle pulse, once per period, in the first cycle of the counted high phase. It is issued only after the synchronized line reads high, so it never occurs while the line is held low.
- R6: Clock stretching works as follows. If a device holds the line low past the block's own low phase, the high phase waits. From the cycle the line is released to the next `edge_fall`, exactly H cycles elapse.
- R7: `rate_warn` is high exactly when `enable` is 1 and `rate_div` is below 10. It is 0 while disabled, whatever the rate.
- R8: Dropping `enable` releases the line and clears both strobes from the next cycle on. Counting restarts from the high-wait state when the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master clock generation enable |
| rate_div | input | 8 | Bit-rate value |
| pre_sel | input | 2 | Prescaler select (1, 4, 16, 64) |
| scl_in | input | 1 | Sampled level of the bus clock line |
| scl_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| edge_rise | output | 1 | Strobe at the start of the counted high phase |
| edge_fall | output | 1 | Strobe at the start of the low phase |
| rate_warn | output | 1 | Unsupported rate programmed while enabled |

## Verification
Phase lengths are measured over every bit-rate value from 0 to 20 with prescale 1, and over chosen values (including 10 and 255) for the larger prescalers. These runs separate a wrong base constant, a wrong prescale mapping and an asymmetric split between high and low. A stretched run holds the line low well past the block's own low phase. It shows whether the high phase waits for the line and whether synchronizer latency is absorbed into H. A mid-phase disable, and rate values on both sides of 10 with the block enabled and disabled, cover the release path and the warning threshold.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  // Phases of the bus clock generator
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,  // line released, waiting to observe it high
    PH_HIGH = 2'd1,  // counting the high phase
    PH_LOW  = 2'd2   // pulling the line low and counting
  } scl_phase_e;
endpackage

// File: rtl/scl_half_calc.sv
module scl_half_calc #(
  parameter int RATE_W    = 8,
  parameter int SEL_W     = 2,
  parameter int PRE_SHIFT = 2,
  parameter int BASE_HALF = 8,
  parameter int HALF_W    = 15
) (
  input  logic [RATE_W-1:0] rate_div,
  input  logic [SEL_W-1:0]  pre_sel,
  output logic [HALF_W-1:0] half_len
);
  localparam int N_PRE = 1 << SEL_W;

  logic [HALF_W-1:0] scaled [N_PRE];

  // One pre-shifted copy of the rate per prescale choice
  for (genvar i = 0; i < N_PRE; i++) begin : g_pre
    assign scaled[i] = HALF_W'(rate_div) << (PRE_SHIFT * i);
  end

  assign half_len = HALF_W'(BASE_HALF) + scaled[pre_sel];
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sh_d[i] = line_in;
    end else begin : g_next
      assign sh_d[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign line_q = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_rate_pkg::*;
#(
  parameter int HALF_W = 15,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_hi,
  input  logic [HALF_W-1:0] half_len,
  output logic              drive_low,
  output logic              tick_rise,
  output logic              tick_fall
);
  scl_phase_e        phase_q, phase_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic [HALF_W-1:0] low_last;
  logic [HALF_W-1:0] high_last;

  // Low phase is counted in full; the high phase omits the cycles
  // spent in synchronizer and wait-state latency.
  assign low_last  = half_len - HALF_W'(1);
  assign high_last = half_len - HALF_W'(LAT + 1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    if (!enable) begin
      phase_d = PH_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (line_hi) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
            rise_d  = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q >= high_last) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
            fall_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + HALF_W'(1);
          end
        end
        PH_LOW: begin
          if (cnt_q >= low_last) begin
            phase_d = PH_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + HALF_W'(1);
          end
        end
        default: begin
          phase_d = PH_WAIT;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign drive_low = (phase_q == PH_LOW);
  assign tick_rise = rise_q;
  assign tick_fall = fall_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int RATE_W      = 8,
  parameter int SEL_W       = 2,
  parameter int PRE_SHIFT   = 2,
  parameter int BASE_HALF   = 8,
  parameter int MIN_RATE    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_div,
  input  logic [SEL_W-1:0]  pre_sel,
  input  logic              scl_in,
  output logic              scl_pull_low,
  output logic              edge_rise,
  output logic              edge_fall,
  output logic              rate_warn
);
  localparam int HALF_W = RATE_W + PRE_SHIFT * ((1 << SEL_W) - 1) + 1;
  localparam int LAT    = SYNC_STAGES + 1;

  logic [HALF_W-1:0] half_len;
  logic              line_hi;

  scl_half_calc #(
    .RATE_W(RATE_W), .SEL_W(SEL_W), .PRE_SHIFT(PRE_SHIFT),
    .BASE_HALF(BASE_HALF), .HALF_W(HALF_W)
  ) u_half (
    .rate_div(rate_div), .pre_sel(pre_sel), .half_len(half_len)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(line_hi)
  );

  scl_phase_fsm #(.HALF_W(HALF_W), .LAT(LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line_hi(line_hi),
    .half_len(half_len), .drive_low(scl_pull_low),
    .tick_rise(edge_rise), .tick_fall(edge_fall)
  );

  assign rate_warn = enable && (rate_div < RATE_W'(MIN_RATE));
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int RATE_W      = 8,
  parameter int SEL_W       = 2,
  parameter int PRE_SHIFT   = 2,
  parameter int BASE_HALF   = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [RATE_W-1:0] rate_div,
  input logic [SEL_W-1:0]  pre_sel,
  input logic              scl_in,
  input logic              scl_pull_low,
  input logic              edge_rise,
  input logic              edge_fall,
  input logic              rate_warn
);
  localparam int CW  = RATE_W + PRE_SHIFT * ((1 << SEL_W) - 1) + 2;
  localparam int LAT = SYNC_STAGES + 1;

  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] exp_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lo_cnt <= '0;
    else if (scl_pull_low) lo_cnt <= lo_cnt + CW'(1);
    else                   lo_cnt <= '0;
  end

  assign exp_half = CW'(BASE_HALF) + (CW'(rate_div) << (PRE_SHIFT * pre_sel));

  assert_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(enable)) |-> (lo_cnt == exp_half));

  assert_fall_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |-> scl_pull_low);

  assert_low_starts_with_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> edge_fall);

  assert_ticks_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_rise && edge_fall));

  assert_rise_after_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |-> (!scl_pull_low && $past(scl_in, LAT)));

  assert_warn_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_warn |-> enable);

  assert_disable_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !edge_rise && !edge_fall));
endmodule

bind scl_rate_gen scl_rate_chk #(
  .RATE_W(RATE_W), .SEL_W(SEL_W), .PRE_SHIFT(PRE_SHIFT),
  .BASE_HALF(BASE_HALF), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rate_div(rate_div),
  .pre_sel(pre_sel), .scl_in(scl_in), .scl_pull_low(scl_pull_low),
  .edge_rise(edge_rise), .edge_fall(edge_fall), .rate_warn(rate_warn)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic       clk;
  logic       rst_n;
  logic       enable;
  logic [7:0] rate_div;
  logic [1:0] pre_sel;
  logic       slave_hold;
  logic       scl_line;
  logic       scl_pull_low;
  logic       edge_rise;
  logic       edge_fall;
  logic       rate_warn;

  int vectors;
  int miscompares;
  int cyc;
  bit done;

  // Open-drain bus: line is high unless the generator or a target pulls it
  assign scl_line = !scl_pull_low && !slave_hold;

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_div(rate_div),
    .pre_sel(pre_sel), .scl_in(scl_line), .scl_pull_low(scl_pull_low),
    .edge_rise(edge_rise), .edge_fall(edge_fall), .rate_warn(rate_warn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int half_of(input int r, input int s);
    return 8 + r * (1 << (2 * s));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Restart the generator with a new configuration
  task automatic restart(input int r, input int s);
    enable = 1'b0;
    rate_div = 8'(r);
    pre_sel = 2'(s);
    repeat (4) @(negedge clk);
    chk("R7 warn while disabled", int'(rate_warn), 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R7 warn threshold", int'(rate_warn), (r < 10) ? 1 : 0);
  endtask

  // Measure one full period following the first falling strobe
  task automatic measure(input int r, input int s);
    int h, lo, hi, rises, falls;
    h = half_of(r, s);
    restart(r, s);
    while (!edge_fall) @(negedge clk);
    lo = 0; falls = 0;
    while (scl_pull_low) begin
      lo++;
      falls += int'(edge_fall);
      @(negedge clk);
    end
    hi = 0; rises = 0;
    while (!edge_fall) begin
      hi++;
      rises += int'(edge_rise);
      @(negedge clk);
    end
    chk("R2 low length", lo, h);
    chk("R3 high length", hi, h);
    chk("R4 one fall strobe per low", falls, 1);
    chk("R5 one rise strobe per high", rises, 1);
  endtask

  initial begin
    vectors = 0; miscompares = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; enable = 1'b0; rate_div = 8'd0; pre_sel = 2'd0; slave_hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pull", int'(scl_pull_low), 0);
    chk("R1 reset rise", int'(edge_rise), 0);
    chk("R1 reset fall", int'(edge_fall), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 disabled pull", int'(scl_pull_low), 0);

    // Full sweep of small rates with prescale 1
    for (int r = 0; r <= 20; r++) measure(r, 0);
    // Chosen rates for the larger prescalers
    measure(0, 1);  measure(5, 1);  measure(10, 1); measure(37, 1);
    measure(0, 2);  measure(3, 2);  measure(10, 2); measure(12, 2);
    measure(0, 3);  measure(1, 3);  measure(9, 3);  measure(255, 3);

    // R6: stretching by a target that holds the line low
    begin
      int h, pulled, rises, to_fall;
      h = half_of(2, 0);
      restart(2, 0);
      while (!edge_fall) @(negedge clk);
      slave_hold = 1'b1;
      pulled = 0; rises = 0;
      for (int k = 0; k < 40; k++) begin
        pulled += int'(scl_pull_low);
        rises += int'(edge_rise);
        @(negedge clk);
      end
      chk("R2 own pull unaffected by stretch", pulled, h);
      chk("R5 no rise while held", rises, 0);
      chk("R6 line still low", int'(scl_line), 0);
      slave_hold = 1'b0;
      to_fall = 0;
      while (!edge_fall) begin
        to_fall++;
        @(negedge clk);
      end
      chk("R6 release to fall", to_fall, h);
    end

    // R8: disable in the middle of a low phase
    begin
      int seen;
      restart(20, 0);
      while (!edge_fall) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R8 low before disable", int'(scl_pull_low), 1);
      enable = 1'b0;
      @(negedge clk);
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        seen += int'(scl_pull_low) + int'(edge_rise) + int'(edge_fall);
        @(negedge clk);
      end
      chk("R8 released while disabled", seen, 0);
      chk("R7 warn off while disabled", int'(rate_warn), 0);
    end
    measure(4, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule